// File: doc/BRIEF.md
# NOR Flash Array Program and Erase Engine

This engine holds the byte array of a modelled serial NOR flash and applies the flash write rules to it on behalf of a command sequencer. A program request writes one byte. The stored value becomes the bitwise AND of the old byte and the new byte, so a program can only clear bits. A build option replaces the AND with a plain overwrite, which models EEPROM-like parts. An erase request names a region kind and an address. The engine then sets every byte of that region to 0xFF, one byte per clock, and drives `busy_o` high while it does so. A third port reads single bytes back.

The sequencer sees one `ready_o` signal. A request is taken only in a cycle where `ready_o` is high. If several requests are present in the same cycle, erase is taken first, then program, then read. Single-cycle flags report four conditions: an erase refused because writes are not enabled, an erase size the device does not list, a program made while writes are not enabled, and a program byte that tries to raise a 0 bit to 1. Sector size, sector count, the two small erase sizes, the capability bits and the overwrite option are all parameters. The defaults are scaled down so that the array stays small.

Top module: `flash_pe_engine`

## Requirements
- R1: While `rst` is high and for exactly DEV = SECTOR_BYTES*SECTOR_COUNT cycles after it is released, `busy_o` is 1. After that, every address reads 0xFF.
- R2: An accepted erase with `wr_en_i`=1 sets every byte of its region to 0xFF and leaves all other bytes unchanged. `erase_kind_i` selects the region: 0 = SMALL_BYTES, 1 = MID_BYTES, 2 = SECTOR_BYTES, 3 = whole device. The region starts at the wrapped address rounded down to a multiple of its size. Kind 3 starts at address 0.
- R3: After an erase is accepted with `wr_en_i`=1, `busy_o` is 1 for exactly the region length in cycles, starting in the next cycle. `ready_o` is 0 during that time.
- R4: An erase accepted with `wr_en_i`=0 changes no byte and does not raise `busy_o`. In the next cycle `err_protect_o` pulses for one cycle.
- R5: An erase of kind 0 when CAP_SMALL=0, or of kind 1 when CAP_MID=0, pulses `err_size_o` in the next cycle. The erase is still carried out under R2 to R4.
- R6: With WRITE_ONES=0, an accepted program stores old AND new. `ready_o` is 0 for the one cycle after the accept, while the byte is written.
- R7: With WRITE_ONES=1, an accepted program stores the new byte unchanged.
- R8: A program accepted with `wr_en_i`=0 is still written. `warn_prog_o` pulses in the second cycle after the accept.
- R9: `warn_one_o` pulses in the second cycle after a program accept when the new byte has a 1 bit where the stored byte has a 0 bit.
- R10: Every address input is taken modulo DEV. With the defaults, address 770 means address 2.
- R11: A read accepted in one cycle returns `rd_valid_o`=1 and the byte in `rd_data_o` in the next cycle.
- R12: Requests are taken only while `ready_o`=1. In the same cycle, erase takes priority over program, and program takes priority over read. Requests that lose or are stalled have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; starts the fill of the array with 0xFF |
| wr_en_i | input | 1 | Write-enable state held by the sequencer |
| erase_req_i | input | 1 | Erase request |
| erase_kind_i | input | 2 | Region kind: 0 small, 1 mid, 2 sector, 3 whole device |
| erase_addr_i | input | AW | Address inside the region to erase |
| prog_req_i | input | 1 | Program request |
| prog_addr_i | input | AW | Program address |
| prog_data_i | input | 8 | Program byte |
| rd_req_i | input | 1 | Read request |
| rd_addr_i | input | AW | Read address |
| ready_o | output | 1 | Requests are accepted in this cycle |
| busy_o | output | 1 | Erase or reset fill in progress |
| rd_valid_o | output | 1 | `rd_data_o` holds a requested byte |
| rd_data_o | output | 8 | Read data |
| err_protect_o | output | 1 | Erase refused because writes are not enabled |
| err_size_o | output | 1 | Erase size not supported by the device |
| warn_prog_o | output | 1 | Program made while writes are not enabled |
| warn_one_o | output | 1 | Program tried to raise a 0 bit to 1 |

## Verification
Each result has a fixed latency, counted in clock edges from the edge that accepts the request:
- read data and `rd_valid_o` are due one edge after the accept;
- the erase flags are due one edge after the accept;
- `busy_o` rises one edge after the accept and falls exactly one region length of edges later;
- the two program warnings are due two edges after the accept, because of the read-modify-write cycle.

The bench holds a behavioural model that advances on the same edge as the design and applies the same latencies. Every output is compared on the falling edge, when it is stable. Directed checks count the busy cycles and read bytes back through the read port once the engine is ready again.

// File: rtl/pe_pkg.sv
package pe_pkg;
  typedef enum logic [1:0] {
    ER_SMALL = 2'd0,
    ER_MID   = 2'd1,
    ER_SECT  = 2'd2,
    ER_CHIP  = 2'd3
  } erase_kind_e;
endpackage

// File: rtl/pe_mem.sv
// Simple dual-port byte array: one write port, one registered read port.
module pe_mem #(
  parameter int DEPTH = 768,
  parameter int AW    = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] arr [DEPTH];

  always_ff @(posedge clk) begin
    if (we) arr[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= arr[raddr];
  end
endmodule

// File: rtl/pe_region.sv
// Maps an erase kind and a wrapped address to the first and last byte of the region.
module pe_region #(
  parameter int SMALL_BYTES  = 16,
  parameter int MID_BYTES    = 64,
  parameter int SECTOR_BYTES = 256,
  parameter int DEV          = 768,
  parameter int AW           = 10
) (
  input  pe_pkg::erase_kind_e kind,
  input  logic [AW-1:0]       addr,
  output logic [AW-1:0]       first,
  output logic [AW-1:0]       last
);
  localparam logic [AW-1:0] SMALL_M = AW'(SMALL_BYTES - 1);
  localparam logic [AW-1:0] MID_M   = AW'(MID_BYTES - 1);
  localparam logic [AW-1:0] SECT_M  = AW'(SECTOR_BYTES - 1);
  localparam logic [AW-1:0] DEV_M   = AW'(DEV - 1);

  logic [AW-1:0] span_m;

  always_comb begin
    unique case (kind)
      pe_pkg::ER_SMALL: span_m = SMALL_M;
      pe_pkg::ER_MID:   span_m = MID_M;
      pe_pkg::ER_SECT:  span_m = SECT_M;
      default:          span_m = DEV_M;
    endcase
    if (kind == pe_pkg::ER_CHIP) begin
      first = '0;
      last  = DEV_M;
    end else begin
      first = addr & ~span_m;
      last  = (addr & ~span_m) + span_m;
    end
  end
endmodule

// File: rtl/pe_walker.sv
// Steps through an address range one byte per clock; after reset it walks the whole array.
module pe_walker #(
  parameter int DEV = 768,
  parameter int AW  = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] first,
  input  logic [AW-1:0] last,
  output logic          active,
  output logic [AW-1:0] cur
);
  logic [AW-1:0] last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b1;
      cur    <= '0;
      last_q <= AW'(DEV - 1);
    end else if (start) begin
      active <= 1'b1;
      cur    <= first;
      last_q <= last;
    end else if (active) begin
      if (cur == last_q) active <= 1'b0;
      else               cur    <= cur + 1'b1;
    end
  end
endmodule

// File: rtl/flash_pe_engine.sv
module flash_pe_engine #(
  parameter int SECTOR_BYTES = 256,
  parameter int SECTOR_COUNT = 3,
  parameter int SMALL_BYTES  = 16,
  parameter int MID_BYTES    = 64,
  parameter bit CAP_SMALL    = 1'b1,
  parameter bit CAP_MID      = 1'b0,
  parameter bit WRITE_ONES   = 1'b0,
  localparam int DEV         = SECTOR_BYTES * SECTOR_COUNT,
  localparam int AW          = $clog2(DEV)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en_i,
  input  logic          erase_req_i,
  input  logic [1:0]    erase_kind_i,
  input  logic [AW-1:0] erase_addr_i,
  input  logic          prog_req_i,
  input  logic [AW-1:0] prog_addr_i,
  input  logic [7:0]    prog_data_i,
  input  logic          rd_req_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic          ready_o,
  output logic          busy_o,
  output logic          rd_valid_o,
  output logic [7:0]    rd_data_o,
  output logic          err_protect_o,
  output logic          err_size_o,
  output logic          warn_prog_o,
  output logic          warn_one_o
);
  import pe_pkg::*;

  localparam logic [AW-1:0] DEV_A = AW'(DEV);

  function automatic logic [AW-1:0] wrap(input logic [AW-1:0] a);
    return (DEV_A != '0 && a >= DEV_A) ? a - DEV_A : a;
  endfunction

  logic          active;
  logic [AW-1:0] walk_addr;
  logic          pend_q;
  logic          pwe_q;
  logic [AW-1:0] pa_q;
  logic [7:0]    pd_q;
  logic [7:0]    mem_q;
  logic          take_erase, take_prog, take_rd, erase_go;
  logic [AW-1:0] reg_first, reg_last;
  erase_kind_e   kind;
  logic          size_bad;
  logic [7:0]    merged;
  logic          mem_we, mem_re;
  logic [AW-1:0] mem_waddr, mem_raddr;
  logic [7:0]    mem_wdata;

  assign kind       = erase_kind_e'(erase_kind_i);
  assign ready_o    = !active && !pend_q;
  assign busy_o     = active;
  assign take_erase = ready_o && erase_req_i;
  assign take_prog  = ready_o && !erase_req_i && prog_req_i;
  assign take_rd    = ready_o && !erase_req_i && !prog_req_i && rd_req_i;
  assign erase_go   = take_erase && wr_en_i;
  assign size_bad   = ((kind == ER_SMALL) && !CAP_SMALL) || ((kind == ER_MID) && !CAP_MID);

  pe_region #(
    .SMALL_BYTES (SMALL_BYTES),
    .MID_BYTES   (MID_BYTES),
    .SECTOR_BYTES(SECTOR_BYTES),
    .DEV         (DEV),
    .AW          (AW)
  ) region_i (
    .kind (kind),
    .addr (wrap(erase_addr_i)),
    .first(reg_first),
    .last (reg_last)
  );

  pe_walker #(.DEV(DEV), .AW(AW)) walker_i (
    .clk   (clk),
    .rst   (rst),
    .start (erase_go),
    .first (reg_first),
    .last  (reg_last),
    .active(active),
    .cur   (walk_addr)
  );

  generate
    if (WRITE_ONES) begin : g_over
      assign merged = pd_q;
    end else begin : g_and
      assign merged = mem_q & pd_q;
    end
  endgenerate

  assign mem_we    = active || pend_q;
  assign mem_waddr = active ? walk_addr : pa_q;
  assign mem_wdata = active ? 8'hFF : merged;
  assign mem_re    = take_prog || take_rd;
  assign mem_raddr = take_prog ? wrap(prog_addr_i) : wrap(rd_addr_i);

  pe_mem #(.DEPTH(DEV), .AW(AW)) mem_i (
    .clk  (clk),
    .we   (mem_we),
    .waddr(mem_waddr),
    .wdata(mem_wdata),
    .re   (mem_re),
    .raddr(mem_raddr),
    .rdata(mem_q)
  );

  assign rd_data_o = mem_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q        <= 1'b0;
      pwe_q         <= 1'b0;
      pa_q          <= '0;
      pd_q          <= '0;
      rd_valid_o    <= 1'b0;
      err_protect_o <= 1'b0;
      err_size_o    <= 1'b0;
      warn_prog_o   <= 1'b0;
      warn_one_o    <= 1'b0;
    end else begin
      pend_q <= take_prog;
      if (take_prog) begin
        pa_q  <= wrap(prog_addr_i);
        pd_q  <= prog_data_i;
        pwe_q <= wr_en_i;
      end
      rd_valid_o    <= take_rd;
      err_protect_o <= take_erase && !wr_en_i;
      err_size_o    <= take_erase && size_bad;
      warn_prog_o   <= pend_q && !pwe_q;
      warn_one_o    <= pend_q && ((~mem_q & pd_q) != 8'h00);
    end
  end
endmodule

// File: rtl/flash_pe_engine_chk.sv
module flash_pe_engine_chk #(
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en_i,
  input logic          erase_req_i,
  input logic          prog_req_i,
  input logic          rd_req_i,
  input logic          ready_o,
  input logic          busy_o,
  input logic          rd_valid_o,
  input logic          err_protect_o,
  input logic          err_size_o,
  input logic          warn_prog_o
);
  AST_ERASE_BUSY: assert property (@(posedge clk) disable iff (rst)
    (erase_req_i && ready_o && wr_en_i) |=> busy_o); // R3
  AST_PROTECT_IDLE: assert property (@(posedge clk) disable iff (rst)
    err_protect_o |-> !busy_o); // R4
  AST_SIZE_SRC: assert property (@(posedge clk) disable iff (rst)
    err_size_o |-> $past(erase_req_i && ready_o)); // R5
  AST_PROG_STALL: assert property (@(posedge clk) disable iff (rst)
    (prog_req_i && ready_o && !erase_req_i) |=> !ready_o); // R6
  AST_WARN_WE: assert property (@(posedge clk) disable iff (rst)
    warn_prog_o |-> $past(!wr_en_i, 2)); // R8
  AST_RD_SRC: assert property (@(posedge clk) disable iff (rst)
    rd_valid_o |-> $past(rd_req_i && ready_o && !erase_req_i && !prog_req_i)); // R11
endmodule

bind flash_pe_engine flash_pe_engine_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .erase_req_i(erase_req_i),
  .prog_req_i(prog_req_i), .rd_req_i(rd_req_i), .ready_o(ready_o),
  .busy_o(busy_o), .rd_valid_o(rd_valid_o), .err_protect_o(err_protect_o),
  .err_size_o(err_size_o), .warn_prog_o(warn_prog_o)
);

// File: tb/flash_pe_engine_tb_top.sv
module flash_pe_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEV = 768;
  localparam int AW  = 10;
  localparam int SZ_SMALL = 16, SZ_MID = 64, SZ_SECT = 256;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rst = 1'b1;
  logic wr_en = 1'b0, erase_req = 1'b0, prog_req = 1'b0, rd_req = 1'b0;
  logic [1:0] kind = 2'd0;
  logic [AW-1:0] e_addr = '0, p_addr = '0, r_addr = '0;
  logic [7:0] p_data = '0;

  logic ready_a, busy_a, rdv_a, prot_a, size_a, wp_a, wo_a;
  logic ready_b, busy_b, rdv_b, prot_b, size_b, wp_b, wo_b;
  logic [7:0] rd_a, rd_b;

  flash_pe_engine dut_i (
    .clk(clk), .rst(rst), .wr_en_i(wr_en), .erase_req_i(erase_req),
    .erase_kind_i(kind), .erase_addr_i(e_addr), .prog_req_i(prog_req),
    .prog_addr_i(p_addr), .prog_data_i(p_data), .rd_req_i(rd_req),
    .rd_addr_i(r_addr), .ready_o(ready_a), .busy_o(busy_a),
    .rd_valid_o(rdv_a), .rd_data_o(rd_a), .err_protect_o(prot_a),
    .err_size_o(size_a), .warn_prog_o(wp_a), .warn_one_o(wo_a));

  flash_pe_engine #(.WRITE_ONES(1'b1)) dut_wo_i (
    .clk(clk), .rst(rst), .wr_en_i(wr_en), .erase_req_i(erase_req),
    .erase_kind_i(kind), .erase_addr_i(e_addr), .prog_req_i(prog_req),
    .prog_addr_i(p_addr), .prog_data_i(p_data), .rd_req_i(rd_req),
    .rd_addr_i(r_addr), .ready_o(ready_b), .busy_o(busy_b),
    .rd_valid_o(rdv_b), .rd_data_o(rd_b), .err_protect_o(prot_b),
    .err_size_o(size_b), .warn_prog_o(wp_b), .warn_one_o(wo_b));

  int n_chk = 0, n_err = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int ref_a[DEV], ref_b[DEV];
  int m_busy = 0, m_pa = 0, m_pd = 0, m_len = 0, m_base = 0, m_wa = 0;
  bit m_pend = 0, m_pwe = 0, m_rdy = 0;
  bit e_rdv = 0, e_prot = 0, e_size = 0, e_wp = 0, e_wo_a = 0, e_wo_b = 0;
  int e_rd_a = 0, e_rd_b = 0;

  function automatic int wrapi(input int a);
    return a % DEV;
  endfunction

  function automatic int span(input int k);
    case (k)
      0: return SZ_SMALL;
      1: return SZ_MID;
      2: return SZ_SECT;
      default: return DEV;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEV; i++) begin ref_a[i] = 255; ref_b[i] = 255; end
      m_busy = DEV; m_pend = 0;
      {e_rdv, e_prot, e_size, e_wp, e_wo_a, e_wo_b} = '0;
    end else begin
      m_rdy = (m_busy == 0) && !m_pend;
      {e_rdv, e_prot, e_size, e_wp, e_wo_a, e_wo_b} = '0;
      if (m_pend) begin
        e_wp   = !m_pwe;
        e_wo_a = ((~ref_a[m_pa]) & m_pd & 255) != 0;
        e_wo_b = ((~ref_b[m_pa]) & m_pd & 255) != 0;
        ref_a[m_pa] = ref_a[m_pa] & m_pd;
        ref_b[m_pa] = m_pd;
        m_pend = 0;
      end
      if (m_busy > 0) m_busy--;
      if (m_rdy) begin
        if (erase_req) begin
          m_len  = span(int'(kind));
          m_base = (kind == 2'd3) ? 0 : (wrapi(int'(e_addr)) / m_len) * m_len;
          e_size = (kind == 2'd1); // default capabilities: small listed, mid not
          if (wr_en) begin
            for (int j = 0; j < m_len; j++) begin
              ref_a[m_base + j] = 255; ref_b[m_base + j] = 255;
            end
            m_busy = m_len;
          end else e_prot = 1;
        end else if (prog_req) begin
          m_pend = 1; m_pa = wrapi(int'(p_addr)); m_pd = int'(p_data); m_pwe = wr_en;
        end else if (rd_req) begin
          m_wa = wrapi(int'(r_addr));
          e_rdv = 1; e_rd_a = ref_a[m_wa]; e_rd_b = ref_b[m_wa];
        end
      end
    end
  end

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      chk("R3 busy", busy_a, (m_busy != 0));
      chk("R3 busy_wo", busy_b, (m_busy != 0));
      chk("R12 ready", ready_a, (m_busy == 0) && !m_pend);
      chk("R11 rd_valid", rdv_a, e_rdv);
      chk("R11 rd_valid_wo", rdv_b, e_rdv);
      if (e_rdv) begin
        chk("R11 rd_data", rd_a, e_rd_a);
        chk("R7 rd_data_wo", rd_b, e_rd_b);
      end
      chk("R4 err_protect", prot_a, e_prot);
      chk("R5 err_size", size_a, e_size);
      chk("R8 warn_prog", wp_a, e_wp);
      chk("R9 warn_one", wo_a, e_wo_a);
      chk("R9 warn_one_wo", wo_b, e_wo_b);
    end
  end

  task automatic wait_ready();
    while (!ready_a) @(negedge clk);
  endtask

  task automatic do_erase(input int k, input int a, input bit we);
    wait_ready();
    wr_en = we; kind = 2'(k); e_addr = AW'(a); erase_req = 1'b1;
    @(negedge clk);
    erase_req = 1'b0;
  endtask

  task automatic erase_count(input int k, input int a, input int exp_len, input string tag);
    int n;
    do_erase(k, a, 1'b1);
    n = 0;
    while (busy_a) begin n++; @(negedge clk); end
    chk(tag, n, exp_len);
  endtask

  task automatic do_prog(input int a, input int d, input bit we);
    wait_ready();
    wr_en = we; p_addr = AW'(a); p_data = 8'(d); prog_req = 1'b1;
    @(negedge clk);
    prog_req = 1'b0;
  endtask

  task automatic rd_chk(input int a, input int ea, input int eb, input string tag);
    wait_ready();
    r_addr = AW'(a); rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    chk({tag, " valid"}, rdv_a, 1);
    chk(tag, rd_a, ea);
    chk({tag, " wo"}, rd_b, eb);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (CLK_PERIOD * 15000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: fill after reset
    n = 0;
    while (busy_a) begin n++; @(negedge clk); end
    chk("R1 reset busy length", n, DEV);
    rd_chk(0, 255, 255, "R1 read 0");
    rd_chk(DEV - 1, 255, 255, "R1 read last");

    // R6 / R7 / R9: AND versus overwrite
    do_prog(16, 8'hA5, 1'b1);
    chk("R6 ready low after accept", ready_a, 0);
    do_prog(16, 8'h3C, 1'b1);
    @(negedge clk);
    chk("R9 warn_one on raise", wo_a, 1);
    rd_chk(16, 8'h24, 8'h3C, "R6 and-merge");

    // R8: program without write enable still lands
    do_prog(32, 8'h0F, 1'b0);
    @(negedge clk);
    chk("R8 warn_prog", wp_a, 1);
    rd_chk(32, 8'h0F, 8'h0F, "R8 written");

    // R10: wrap
    do_prog(770, 8'h5A, 1'b1);
    rd_chk(2, 8'h5A, 8'h5A, "R10 wrap program");
    rd_chk(770, 8'h5A, 8'h5A, "R10 wrap read");

    // R2 / R3: small erase, unaligned address
    for (int i = 64; i < 96; i++) do_prog(i, i, 1'b1);
    erase_count(0, 69, SZ_SMALL, "R3 small busy length");
    rd_chk(64, 255, 255, "R2 small first");
    rd_chk(79, 255, 255, "R2 small last");
    rd_chk(80, 80, 80, "R2 outside kept");

    // R5: mid erase, capability clear, still erased
    do_erase(1, 127, 1'b1);
    chk("R5 size flag", size_a, 1);
    rd_chk(80, 255, 255, "R5 erase still done");

    // R4: erase without write enable
    do_erase(2, 16, 1'b0);
    chk("R4 protect flag", prot_a, 1);
    chk("R4 not busy", busy_a, 0);
    rd_chk(16, 8'h24, 8'h3C, "R4 data kept");

    // R12: erase beats program and read in one cycle
    wait_ready();
    wr_en = 1'b1; kind = 2'd0; e_addr = '0; erase_req = 1'b1;
    p_addr = AW'(48); p_data = 8'h00; prog_req = 1'b1;
    r_addr = AW'(16); rd_req = 1'b1;
    @(negedge clk);
    {erase_req, prog_req, rd_req} = '0;
    chk("R12 losers dropped", rdv_a, 0);
    rd_chk(48, 255, 255, "R12 program dropped");
    rd_chk(2, 255, 255, "R2 region 0 erased");

    // R12: program held during a sector erase
    do_erase(2, 496, 1'b1);
    wr_en = 1'b1; p_addr = AW'(256); p_data = 8'h77; prog_req = 1'b1;
    begin
      bit r;
      do begin r = ready_a; @(negedge clk); end while (!r);
    end
    prog_req = 1'b0;
    rd_chk(256, 8'h77, 8'h77, "R12 stalled program");
    rd_chk(511, 255, 255, "R2 sector end");

    // R2: whole device
    erase_count(3, 300, DEV, "R2 chip busy length");
    rd_chk(32, 255, 255, "R2 chip erased");
    rd_chk(256, 255, 255, "R2 chip erased sector");

    // R7: overwrite can raise bits
    do_prog(40, 8'h00, 1'b1);
    do_prog(40, 8'h81, 1'b1);
    rd_chk(40, 8'h00, 8'h81, "R7 overwrite");

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule